// File: doc/BRIEF.md
# Bit-Flipping Deterministic Scan Pattern Source

This block supplies stimulus for a scan-based self-test. A linear feedback shift register runs one step for each shift cycle and provides a pseudorandom bit stream for the scan chain. A small combinational correction stage sits between the register and the scan-in pin. It looks at the current pattern index and at the bit index within that pattern. When the pair matches an entry of a table fixed at design time, it inverts the outgoing bit. The chosen deterministic patterns then appear in the stream, and every other random bit passes through unchanged.

A pair of counters sequences the session. Each pattern shifts for a parameterized number of cycles with scan enable high, then takes one capture cycle with scan enable low. After the capture of the last pattern the block raises its done flag and stays idle. A serial signature register compacts the chain's scan-out bit on every shift cycle, so that a response signature is available at the end of the session.

Top module: `bfb_gen`

## Requirements
- R1: While reset is held and in the cycle after it is released, scan enable is 1, done is 0, the signature is 0 and scan-in equals bit 0 of the seed XOR the flip decision for pattern 0, bit 0.
- R2: The shift register is loaded with the nonzero seed on reset. Each shift cycle moves it to (state >> 1) XOR (TAPS if state bit 0 is 1, else 0), with default TAPS 16'hB400 and seed 16'hACE1. The state never becomes zero.
- R3: During a shift cycle, scan-in equals bit 0 of the current shift-register state XOR the flip decision.
- R4: The flip decision is 1 exactly when the current (pattern, bit) pair equals any entry of the flip table. The default table is (0,0), (3,7), (7,4), (7,4), (15,7). A listed pair that appears twice is still inverted once.
- R5: Each pattern is CHAIN_LEN (default 8) shift cycles with scan enable 1, followed by one capture cycle with scan enable 0 and scan-in 0. The shift register does not advance in a capture cycle.
- R6: Bit index 0 is the first bit shifted in each pattern. The bit index counts up to CHAIN_LEN-1, and the pattern index moves up by one after each capture.
- R7: Done rises in the cycle after the capture of pattern NUM_PATTERNS-1 (default 16), so the session lasts NUM_PATTERNS*(CHAIN_LEN+1) cycles. Done then stays 1, with scan enable 0 and scan-in 0.
- R8: On each shift cycle the signature moves to (sig >> 1) XOR (POLY if sig bit 0 is 1, else 0) XOR (scanOut placed at the top bit), with default POLY 16'h8016. In all other cycles it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; starts a new session |
| scanOut | input | 1 | Bit returned from the end of the scan chain |
| scanIn | output | 1 | Bit to shift into the scan chain |
| scanEn | output | 1 | 1 on shift cycles, 0 on capture and after the session |
| testDone | output | 1 | Session finished |
| signature | output | SIG_W | Compacted response signature |

## Verification
The flip stage and the counter wrap can act in the same cycle. This happens when a table entry names the last bit of a pattern: the inverted bit has to leave on that cycle, and the following cycle has to be the capture. The default table places such entries on pattern 3 and on the very last pattern. In the second case the flip, the wrap and the final capture that leads to done all follow back to back. A scoreboard holds the expected scan enable, scan-in and done for every cycle, computed from an independent model of the register and the table. It also tracks a model signature, and the run is judged cycle by cycle against these values.

// File: rtl/bfb_pkg.sv
package bfb_pkg;
  typedef struct packed {
    logic shiftEn;
    logic capture;
    logic done;
  } ctrlStrobes_t;
endpackage

// File: rtl/bfb_ctrl.sv
module bfb_ctrl
  import bfb_pkg::*;
#(
  parameter int CHAIN_LEN    = 8,
  parameter int NUM_PATTERNS = 16,
  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int PAT_W = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  output ctrlStrobes_t     strobes,
  output logic [BIT_W-1:0] bitIdx,
  output logic [PAT_W-1:0] patIdx
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);
  localparam logic [PAT_W-1:0] LAST_PAT = PAT_W'(NUM_PATTERNS - 1);

  logic [BIT_W-1:0] bitCnt;
  logic [PAT_W-1:0] patCnt;
  logic             capPhase;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      patCnt   <= '0;
      capPhase <= 1'b0;
      doneQ    <= 1'b0;
    end else if (!doneQ) begin
      if (capPhase) begin
        capPhase <= 1'b0;
        if (patCnt == LAST_PAT) doneQ  <= 1'b1;
        else                    patCnt <= patCnt + 1'b1;
      end else if (bitCnt == LAST_BIT) begin
        bitCnt   <= '0;
        capPhase <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.shiftEn = !doneQ && !capPhase;
    strobes.capture = capPhase && !doneQ;
    strobes.done    = doneQ;
  end

  assign bitIdx = bitCnt;
  assign patIdx = patCnt;

  assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);
  assert_capture_bitzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> (bitCnt == '0));
  assert_capture_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> strobes.done);
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.done) |-> (patCnt == LAST_PAT));
endmodule

// File: rtl/bfb_datapath.sv
module bfb_datapath
  import bfb_pkg::*;
#(
  parameter int                 LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1,
  parameter int                 SIG_W     = 16,
  parameter logic [SIG_W-1:0]   SIG_POLY  = 16'h8016,
  parameter int                 NUM_FLIPS = 5,
  parameter int unsigned        FLIP_PAT [NUM_FLIPS] = '{0, 3, 7, 7, 15},
  parameter int unsigned        FLIP_BIT [NUM_FLIPS] = '{0, 7, 4, 4, 7},
  parameter int                 BIT_W     = 3,
  parameter int                 PAT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic [PAT_W-1:0] patIdx,
  input  logic             scanOut,
  output logic             scanIn,
  output logic [SIG_W-1:0] signature
);
  logic [LFSR_W-1:0]    lfsr;
  logic [NUM_FLIPS-1:0] flipHit;
  logic                 flip;

  for (genvar i = 0; i < NUM_FLIPS; i++) begin : g_flip
    assign flipHit[i] = (patIdx == PAT_W'(FLIP_PAT[i])) &&
                        (bitIdx == BIT_W'(FLIP_BIT[i]));
  end
  assign flip   = |flipHit;
  assign scanIn = strobes.shiftEn & (lfsr[0] ^ flip);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr      <= LFSR_SEED;
      signature <= '0;
    end else if (strobes.shiftEn) begin
      lfsr      <= (lfsr >> 1) ^ ({LFSR_W{lfsr[0]}} & LFSR_TAPS);
      signature <= (signature >> 1) ^ ({SIG_W{signature[0]}} & SIG_POLY)
                   ^ (SIG_W'(scanOut) << (SIG_W - 1));
    end
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  assert_lfsr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn |=> $stable(lfsr));
  assert_sig_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn |=> $stable(signature));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |-> !scanIn);
endmodule

// File: rtl/bfb_gen.sv
module bfb_gen
  import bfb_pkg::*;
#(
  parameter int                CHAIN_LEN    = 8,
  parameter int                NUM_PATTERNS = 16,
  parameter int                LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS    = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED    = 16'hACE1,
  parameter int                SIG_W        = 16,
  parameter logic [SIG_W-1:0]  SIG_POLY     = 16'h8016,
  parameter int                NUM_FLIPS    = 5,
  parameter int unsigned       FLIP_PAT [NUM_FLIPS] = '{0, 3, 7, 7, 15},
  parameter int unsigned       FLIP_BIT [NUM_FLIPS] = '{0, 7, 4, 4, 7}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanOut,
  output logic             scanIn,
  output logic             scanEn,
  output logic             testDone,
  output logic [SIG_W-1:0] signature
);
  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int PAT_W = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1;

  ctrlStrobes_t     strobes;
  logic [BIT_W-1:0] bitIdx;
  logic [PAT_W-1:0] patIdx;

  bfb_ctrl #(.CHAIN_LEN(CHAIN_LEN), .NUM_PATTERNS(NUM_PATTERNS)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx), .patIdx(patIdx)
  );

  bfb_datapath #(
    .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED),
    .SIG_W(SIG_W), .SIG_POLY(SIG_POLY), .NUM_FLIPS(NUM_FLIPS),
    .FLIP_PAT(FLIP_PAT), .FLIP_BIT(FLIP_BIT), .BIT_W(BIT_W), .PAT_W(PAT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx), .patIdx(patIdx),
    .scanOut(scanOut), .scanIn(scanIn), .signature(signature)
  );

  assign scanEn   = strobes.shiftEn;
  assign testDone = strobes.done;
endmodule

// File: tb/bfb_gen_tb.sv
module bfb_gen_tb;
  localparam int CL = 8;
  localparam int NP = 16;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [15:0] POLY = 16'h8016;
  localparam int NF = 5;
  localparam int FP [NF] = '{0, 3, 7, 7, 15};
  localparam int FB [NF] = '{0, 7, 4, 4, 7};

  typedef struct {
    logic  en;
    logic  si;
    logic  dn;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanOut = 1'b0;
  logic scanIn, scanEn, testDone;
  logic [15:0] signature;

  item_t q[$];
  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;
  logic [15:0] modelSig = '0;

  always #2 clk = ~clk;

  bfb_gen u_dut (
    .clk(clk), .rstN(rstN), .scanOut(scanOut), .scanIn(scanIn),
    .scanEn(scanEn), .testDone(testDone), .signature(signature)
  );

  function automatic logic isFlip(int p, int b);
    logic hit = 1'b0;
    for (int i = 0; i < NF; i++) if (FP[i] == p && FB[i] == b) hit = 1'b1;
    return hit;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: expected per-cycle items from the register and table model
  task automatic pushExpected();
    logic [15:0] l = SEED;
    item_t it;
    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < CL; b++) begin
        it.en = 1'b1;
        it.si = l[0] ^ isFlip(p, b);
        it.dn = 1'b0;
        it.tag = isFlip(p, b) ? "R4" : ((b == 0) ? "R6" : "R3");
        q.push_back(it);
        l = (l >> 1) ^ ({16{l[0]}} & TAPS);
      end
      it.en = 1'b0; it.si = 1'b0; it.dn = 1'b0; it.tag = "R5";
      q.push_back(it);
    end
    for (int k = 0; k < 6; k++) begin
      it.en = 1'b0; it.si = 1'b0; it.dn = 1'b1; it.tag = "R7";
      q.push_back(it);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  // monitor: pop one item per cycle and compare
  initial begin
    item_t it;
    int cyc;
    logic so;
    pushExpected();
    repeat (3) @(negedge clk);
    // R1: held in reset
    #1;
    check("R1", "scanEn in reset", {15'b0, scanEn}, 16'd1);
    check("R1", "done in reset", {15'b0, testDone}, 16'd0);
    rstN = 1'b1;
    #1;
    check("R1", "scanEn after reset", {15'b0, scanEn}, 16'd1);
    check("R1", "done after reset", {15'b0, testDone}, 16'd0);
    check("R1", "signature after reset", signature, 16'd0);
    check("R1", "first scanIn", {15'b0, scanIn}, {15'b0, SEED[0] ^ isFlip(0, 0)});
    cyc = 0;
    while (q.size() > 0) begin
      it = q.pop_front();
      check(it.tag, "scanEn", {15'b0, scanEn}, {15'b0, it.en});
      check(it.tag, "scanIn", {15'b0, scanIn}, {15'b0, it.si});
      check("R7", "done", {15'b0, testDone}, {15'b0, it.dn});
      check("R8", "signature", signature, modelSig);
      so = cyc[0] ^ cyc[2] ^ cyc[5];
      scanOut = so;
      if (it.en)
        modelSig = (modelSig >> 1) ^ ({16{modelSig[0]}} & POLY) ^ ({15'b0, so} << 15);
      cyc++;
      @(negedge clk);
      #1;
    end
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL R7 watchdog: done %b expected 1", testDone);
      summary();
      $finish;
    end
  end
endmodule